// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Register Block

This block is the host-visible register front end of a two-channel bus-master disk DMA engine. A 16-byte I/O window is split into one 8-byte slice per channel. The lower half of each slice holds a command byte and a status byte. Only single-byte accesses reach these two bytes. The upper half holds the 32-bit physical-region descriptor table pointer, which only full-word accesses reach. The block decodes one access per cycle. It applies the status byte's mixed rules: some bits are plain read/write, some are kept on a write, and some clear when a one is written to them. It also exposes the start and direction controls to the data mover.

Each channel also receives a drive-side interrupt level and a DMA error pulse. Both are folded into that channel's status byte. The interrupt level is also registered into a per-channel flag byte (bit 7) and onto a legacy interrupt line. Line 0 stands for IRQ 14 and line 1 for IRQ 15.

Top module: `bmide_regfile`

## Requirements
- R1: After reset, and again whenever rst_ni is low, every command, status and pointer register of both channels reads zero. legacy_irq_o, irq_flag_o, dma_start_o and dma_dir_o are all zero.
- R2: Channel n owns offsets n*8..n*8+7. A byte read (size_i=0) returns the command byte at offset +0, the status byte at offset +2 and 0xFF at offsets +1 and +3, in rdata_o[7:0] with the upper bits zero. Byte writes to +1 and +3 change nothing.
- R3: A read at offsets +0..+3 with size_i=1 (half) returns 0x0000FFFF, and with size_i=2 or 3 (word) returns 0xFFFFFFFF. Non-byte writes there change nothing.
- R4: A byte write to status loads bits 6:5 from the written byte and keeps bit 0. It clears bits 2:1 where the written byte has a one and keeps them where it has a zero. Bits 7, 4 and 3 read zero.
- R5: A byte write to command stores bit 0 (start, driven on dma_start_o) and bit 3 (direction, driven on dma_dir_o); the other command bits read zero. Writing start 0->1 sets status bit 0 and writing 1->0 clears it.
- R6: A high drv_irq_i[n] in a cycle sets status bit 2 of channel n. A high dma_err_i[n] sets status bit 1. Each stays set until software writes a one to it, and a set in the same cycle as that clearing write wins.
- R7: One clock after drv_irq_i[n] changes, legacy_irq_o[n] and bit 7 of flag byte n (irq_flag_o[n*8+7]) take its value. The other flag bits are zero.
- R8: A word write (size_i=2) at offset +4 stores wdata_i with bits 1:0 forced to zero, and a word read there returns it. Any other access at +4..+7 reads all ones for its width (byte 0xFF, half 0x0000FFFF) and writes nothing.
- R9: An access to one channel's slice leaves the other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 half, 2/3 word |
| addr_i | input | 4 | Byte offset in the window |
| wdata_i | input | 32 | Write data (byte writes use bits 7:0) |
| rdata_o | output | 32 | Read data, zero when no read |
| drv_irq_i | input | 2 | Drive-side interrupt level per channel |
| dma_err_i | input | 2 | DMA error pulse per channel |
| dma_start_o | output | 2 | Command start bit per channel |
| dma_dir_o | output | 2 | Command direction bit per channel |
| irq_flag_o | output | 16 | Flag byte per channel, bit 7 mirrors the interrupt |
| legacy_irq_o | output | 2 | Legacy interrupt lines (0: IRQ 14, 1: IRQ 15) |

## Verification
Read data is combinational from register state. It is due in the same cycle as the request, and the bench samples it 1 ns after driving the request on the falling edge. Register writes, status events and the interrupt mirror all land on the next rising edge. The bench therefore checks them at the following falling edge. For the mirror, it also checks in the cycle of the input change that the output has not yet moved. The set-versus-clear race is checked by driving the event and the clearing write in the same cycle.

// File: rtl/bmide_pkg.sv
package bmide_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  localparam int SLICE_BYTES = 8;
  localparam logic [1:0] OFF_CMD  = 2'd0;
  localparam logic [1:0] OFF_STAT = 2'd2;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int FLAG_BIT      = 7;
  localparam logic [7:0] STAT_RO_ZERO = 8'h98;

  function automatic logic [31:0] ones_for(acc_size_e sz);
    case (sz)
      SZ_BYTE: ones_for = 32'h0000_00FF;
      SZ_HALF: ones_for = 32'h0000_FFFF;
      default: ones_for = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bmide_chan.sv
module bmide_chan
  import bmide_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_wr_i,
  input  logic [1:0]       sub_i,
  input  logic [PTR_W-1:0] wdata_i,
  input  logic             ptr_wr_i,
  input  logic             irq_i,
  input  logic             err_i,
  output logic [7:0]       cmd_o,
  output logic [7:0]       stat_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] PTR_MASK = {{(PTR_W-2){1'b1}}, 2'b00};
  localparam logic [7:0] CMD_MASK = 8'h09;

  logic [7:0]       cmd_q, stat_q, stat_d, wb;
  logic [PTR_W-1:0] ptr_q;
  logic             cmd_wr, stat_wr;

  assign wb      = wdata_i[7:0];
  assign cmd_wr  = cs_wr_i && (sub_i == OFF_CMD);
  assign stat_wr = cs_wr_i && (sub_i == OFF_STAT);

  always_comb begin
    stat_d = stat_q;
    if (stat_wr)
      stat_d = (wb & 8'h60) | (stat_q & ~wb & 8'h06) | (stat_q & 8'h01);
    if (cmd_wr) begin
      if (wb[CMD_START_BIT] && !cmd_q[CMD_START_BIT]) stat_d[0] = 1'b1;
      if (!wb[CMD_START_BIT] && cmd_q[CMD_START_BIT]) stat_d[0] = 1'b0;
    end
    // events win over a same-cycle clear
    if (irq_i) stat_d[2] = 1'b1;
    if (err_i) stat_d[1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      stat_q <= '0;
      ptr_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (cmd_wr)   cmd_q <= wb & CMD_MASK;
      if (ptr_wr_i) ptr_q <= wdata_i & PTR_MASK;
    end
  end

  assign cmd_o  = cmd_q;
  assign stat_o = stat_q;
  assign ptr_o  = ptr_q;

  a_r5_start_sets_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wb[CMD_START_BIT] && !cmd_q[CMD_START_BIT]) |=> stat_q[0]);
  a_r5_stop_clears_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !wb[CMD_START_BIT] && cmd_q[CMD_START_BIT]) |=> !stat_q[0]);
  a_r6_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> stat_q[1]);
  a_r6_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[2] && !(stat_wr && wb[2])) |=> stat_q[2]);
  a_r4_ro_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr |=> ((stat_q & STAT_RO_ZERO) == 8'h00));
  a_r8_ptr_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr_i |=> (ptr_q == ($past(wdata_i) & PTR_MASK)));
endmodule

// File: rtl/bmide_irq_mirror.sv
module bmide_irq_mirror
  import bmide_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CH-1:0]     irq_i,
  output logic [NUM_CH*8-1:0]   flag_o,
  output logic [NUM_CH-1:0]     line_o
);
  logic [NUM_CH-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= irq_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    always_comb begin
      flag_o[c*8 +: 8]           = 8'h00;
      flag_o[c*8 + FLAG_BIT]     = flag_q[c];
    end

    a_r7_line_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] |=> line_o[c]);
    a_r7_line_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_i[c] |=> !line_o[c]);
  end

  assign line_o = flag_q;
endmodule

// File: rtl/bmide_regfile.sv
module bmide_regfile
  import bmide_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PTR_W  = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [1:0]          size_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [PTR_W-1:0]    wdata_i,
  output logic [PTR_W-1:0]    rdata_o,
  input  logic [NUM_CH-1:0]   drv_irq_i,
  input  logic [NUM_CH-1:0]   dma_err_i,
  output logic [NUM_CH-1:0]   dma_start_o,
  output logic [NUM_CH-1:0]   dma_dir_o,
  output logic [NUM_CH*8-1:0] irq_flag_o,
  output logic [NUM_CH-1:0]   legacy_irq_o
);
  acc_size_e         sz;
  logic [CH_W-1:0]   ch_idx;
  logic [1:0]        sub;
  logic              ptr_half;
  logic [7:0]        cmd_a  [NUM_CH];
  logic [7:0]        stat_a [NUM_CH];
  logic [PTR_W-1:0]  ptr_a  [NUM_CH];

  assign sz       = acc_size_e'(size_i);
  assign ch_idx   = addr_i[ADDR_W-1:3];
  assign ptr_half = addr_i[2];
  assign sub      = addr_i[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel, cs_wr, ptr_wr;
    assign sel    = req_i && we_i && (ch_idx == CH_W'(c));
    assign cs_wr  = sel && !ptr_half && (sz == SZ_BYTE);
    assign ptr_wr = sel && ptr_half && (sz == SZ_WORD) && (sub == 2'd0);

    bmide_chan #(.PTR_W(PTR_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cs_wr_i (cs_wr),
      .sub_i   (sub),
      .wdata_i (wdata_i),
      .ptr_wr_i(ptr_wr),
      .irq_i   (drv_irq_i[c]),
      .err_i   (dma_err_i[c]),
      .cmd_o   (cmd_a[c]),
      .stat_o  (stat_a[c]),
      .ptr_o   (ptr_a[c])
    );

    assign dma_start_o[c] = cmd_a[c][CMD_START_BIT];
    assign dma_dir_o[c]   = cmd_a[c][CMD_DIR_BIT];
  end

  bmide_irq_mirror #(.NUM_CH(NUM_CH)) u_mirror (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (drv_irq_i),
    .flag_o(irq_flag_o),
    .line_o(legacy_irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && (int'(ch_idx) < NUM_CH)) begin
      if (!ptr_half) begin
        if (sz == SZ_BYTE) begin
          case (sub)
            OFF_CMD:  rdata_o = PTR_W'(cmd_a[ch_idx]);
            OFF_STAT: rdata_o = PTR_W'(stat_a[ch_idx]);
            default:  rdata_o = PTR_W'(8'hFF);
          endcase
        end else begin
          rdata_o = PTR_W'(ones_for(sz));
        end
      end else if ((sz == SZ_WORD) && (sub == 2'd0)) begin
        rdata_o = ptr_a[ch_idx];
      end else begin
        rdata_o = PTR_W'(ones_for(sz));
      end
    end
  end

  a_r3_half_reads_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !ptr_half && (sz == SZ_HALF)) |-> (rdata_o == PTR_W'(32'h0000_FFFF)));
  a_r1_flags_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_flag_o & ~{NUM_CH{8'h80}}) == '0));
endmodule

// File: tb/bmide_regfile_tb_top.sv
module bmide_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq = '0, err = '0;
  logic [1:0]  start_o, dir_o, legacy;
  logic [15:0] flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bmide_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .drv_irq_i(irq),
    .dma_err_i(err), .dma_start_o(start_o), .dma_dir_o(dir_o),
    .irq_flag_o(flags), .legacy_irq_o(legacy)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [1:0] s, logic [31:0] exp, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; size = s;
    #1 chk(tag, rdata, exp);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset(string tag);
    rd(4'd0, 2'd0, 32'h0, {tag, " ch0 cmd"});
    rd(4'd2, 2'd0, 32'h0, {tag, " ch0 stat"});
    rd(4'd4, 2'd2, 32'h0, {tag, " ch0 ptr"});
    rd(4'd10, 2'd0, 32'h0, {tag, " ch1 stat"});
    rd(4'd12, 2'd2, 32'h0, {tag, " ch1 ptr"});
    chk({tag, " outputs"}, {start_o, dir_o, legacy, flags}, 32'h0);
  endtask

  task automatic t_decode;
    wr(4'd0, 2'd0, 32'hFF);
    rd(4'd0, 2'd0, 32'h09, "R5 cmd keeps bits 0,3");
    rd(4'd1, 2'd0, 32'hFF, "R2 off1 reads FF");
    rd(4'd3, 2'd0, 32'hFF, "R2 off3 reads FF");
    wr(4'd1, 2'd0, 32'h00);
    wr(4'd3, 2'd0, 32'hFF);
    rd(4'd0, 2'd0, 32'h09, "R2 cmd after off1/3 writes");
    rd(4'd2, 2'd0, 32'h01, "R2 stat after off1/3 writes");
  endtask

  task automatic t_nonbyte;
    wr(4'd0, 2'd1, 32'h0);
    wr(4'd0, 2'd2, 32'h0);
    wr(4'd2, 2'd1, 32'hFFFF);
    rd(4'd0, 2'd0, 32'h09, "R3 cmd unchanged by wide writes");
    rd(4'd2, 2'd0, 32'h01, "R3 stat unchanged by wide writes");
    rd(4'd0, 2'd1, 32'h0000FFFF, "R3 half read");
    rd(4'd0, 2'd2, 32'hFFFFFFFF, "R3 word read");
    rd(4'd2, 2'd3, 32'hFFFFFFFF, "R3 size3 read");
  endtask

  task automatic t_start_stop;
    chk("R5 start/dir out", {dir_o[0], start_o[0]}, 32'h3);
    wr(4'd0, 2'd0, 32'h00);
    rd(4'd2, 2'd0, 32'h00, "R5 stop clears active");
    chk("R5 start/dir out cleared", {dir_o[0], start_o[0]}, 32'h0);
    wr(4'd0, 2'd0, 32'h01);
    rd(4'd2, 2'd0, 32'h01, "R5 start sets active");
    chk("R5 start out", start_o, 32'h1);
  endtask

  task automatic t_status;
    @(negedge clk); err[0] = 1'b1;
    @(negedge clk); err[0] = 1'b0;
    rd(4'd2, 2'd0, 32'h03, "R6 error sets bit1");
    @(negedge clk); irq[0] = 1'b1;
    @(negedge clk); irq[0] = 1'b0;
    rd(4'd2, 2'd0, 32'h07, "R6 irq sets bit2");
    rd(4'd2, 2'd0, 32'h07, "R6 bits sticky");
    wr(4'd2, 2'd0, 32'h9A);
    rd(4'd2, 2'd0, 32'h05, "R4 w1c bit1, keep bit2/0");
    wr(4'd2, 2'd0, 32'h64);
    rd(4'd2, 2'd0, 32'h61, "R4 load 6:5, clear bit2");
    wr(4'd2, 2'd0, 32'h00);
    rd(4'd2, 2'd0, 32'h01, "R4 bits 6:5 rewritten, bit0 kept");
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    err[0] = 1'b1; req = 1'b1; we = 1'b1; addr = 4'd2; size = 2'd0; wdata = 32'h02;
    @(negedge clk);
    err[0] = 1'b0; req = 1'b0; we = 1'b0;
    rd(4'd2, 2'd0, 32'h03, "R6 set wins over clear");
    wr(4'd2, 2'd0, 32'h02);
    rd(4'd2, 2'd0, 32'h01, "R6 later clear works");
  endtask

  task automatic t_irq_mirror;
    @(negedge clk); irq[1] = 1'b1;
    #1 chk("R7 no change same cycle", legacy, 32'h0);
    @(negedge clk);
    chk("R7 line follows rise", legacy, 32'h2);
    chk("R7 flag byte follows rise", flags, 32'h8000);
    irq[1] = 1'b0;
    @(negedge clk);
    chk("R7 line follows fall", legacy, 32'h0);
    chk("R7 flag byte follows fall", flags, 32'h0000);
    rd(4'd10, 2'd0, 32'h04, "R6 ch1 irq bit2");
  endtask

  task automatic t_ptr;
    wr(4'd4, 2'd2, 32'h12345677);
    rd(4'd4, 2'd2, 32'h12345674, "R8 ptr align");
    wr(4'd5, 2'd0, 32'hAA);
    wr(4'd4, 2'd1, 32'hBEEF);
    rd(4'd4, 2'd2, 32'h12345674, "R8 narrow writes ignored");
    rd(4'd4, 2'd0, 32'hFF, "R8 byte read ones");
    rd(4'd6, 2'd1, 32'h0000FFFF, "R8 half read ones");
    wr(4'd12, 2'd2, 32'hDEADBEEF);
    rd(4'd12, 2'd2, 32'hDEADBEEC, "R8 ch1 ptr");
    rd(4'd4, 2'd2, 32'h12345674, "R9 ch0 ptr untouched");
  endtask

  task automatic t_chan_indep;
    wr(4'd8, 2'd0, 32'h09);
    rd(4'd10, 2'd0, 32'h05, "R9 ch1 active");
    rd(4'd8, 2'd0, 32'h09, "R9 ch1 cmd");
    rd(4'd0, 2'd0, 32'h01, "R9 ch0 cmd untouched");
    rd(4'd2, 2'd0, 32'h01, "R9 ch0 stat untouched");
    chk("R9 start out", start_o, 32'h3);
    chk("R9 dir out", dir_o, 32'h2);
  endtask

  initial begin
    #3;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    t_reset("R1 reset");
    t_decode();
    t_nonbyte();
    t_start_stop();
    t_status();
    t_set_wins();
    t_irq_mirror();
    t_ptr();
    t_chan_indep();
    @(negedge clk); irq = 2'b11;
    @(negedge clk); rst_n = 1'b0; irq = 2'b00;
    #1 chk("R1 async reset outputs", {start_o, dir_o, legacy, flags}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    t_reset("R1 second reset");
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule